// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides a high-rate input clock by a programmable ratio of M·N + A. It does this by steering a dual-modulus prescaler and counting the prescaler's output pulses. Two cooperating down-counters run on the slow prescaler pulses. The swallow counter holds the modulus-control line high, so the prescaler divides by M+1, for the first A prescaler periods. The main counter then lets the prescaler divide by M until N prescaler periods have passed in total. The result is a single-cycle divided pulse that feeds a phase detector. No counter in the block has to run at the full input rate.

M is 64 or 128, chosen by one select input. The block includes a synthesizable behavioural prescaler clocked by the input clock, so it can be simulated on its own. Settings of N, A and the modulus select are captured only at a cycle boundary, so every divided period uses one ratio. A power-save input holds the counters and keeps the divided output quiet. A combinational flag reports settings that are out of range.

Top module: `swallow_divider`

## Requirements
- R1: The interval between consecutive `div_out` pulses is exactly M·N + A input clock cycles, where N (`n_cnt`, unsigned) and A (`a_cnt`, unsigned) are the captured settings.
- R2: M is 64 when `wide_mod` is 0 and 128 when `wide_mod` is 1. The prescaler period is M+1 input cycles while `mod_ctl` is 1 at the end of that period, and M otherwise.
- R3: Within each divided period, `mod_ctl` is 1 for exactly A·(M+1) input cycles, all at the start of the period. Once it falls, it stays 0 until the next boundary.
- R4: When the captured A is 0, `mod_ctl` stays 0 for the whole divided period.
- R5: A change to `n_cnt`, `a_cnt` or `wide_mod` in the middle of a period leaves that period's length unchanged. The new values govern the periods from the next boundary on.
- R6: While `pwr_save` is 1, `div_out` stays 0 and the counters reload. After `pwr_save` falls, the first `div_out` pulse is seen exactly M·N + A cycles later.
- R7: `cfg_bad` is 1 exactly when `n_cnt` < 3 or `a_cnt` ≥ `n_cnt`, evaluated combinationally on the inputs.
- R8: `div_out` is a pulse one input cycle wide. It is registered in the cycle after the prescaler pulse that ends the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock (the divided signal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_save | input | 1 | Holds counters in reload and silences the output |
| wide_mod | input | 1 | Modulus select: 0 gives 64/65, 1 gives 128/129 |
| n_cnt | input | 11 | Main count N, legal range 3 to 2047 |
| a_cnt | input | 7 | Swallow count A, 0 to 127, must be below N |
| mod_ctl | output | 1 | Modulus control; 1 requests M+1 |
| pre_out | output | 1 | Prescaler output pulse, one cycle per prescaler period |
| div_out | output | 1 | Divided output pulse, once per M·N + A cycles |
| cfg_bad | output | 1 | Illegal-setting flag |

## Verification
The assertions check on every cycle that the shape within a period is right. They check that `mod_ctl` never rises again after it has fallen, that it stays low when A is 0, and that the captured modulus select moves only at a boundary. They also check that `div_out` is a single cycle that follows each period end and stays low under power save. The exact period length, the count of M+1 cycles, the deferral of a mid-period setting change, and the release latency after power save are all absolute cycle counts. Only the bench's measured sweeps over N, A and both moduli can show these.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

  // Length in input cycles of one prescaler period.
  function automatic int pre_len(input int low_log2, input logic wide, input logic plus);
    int base;
    base = 1 << (low_log2 + (wide ? 1 : 0));
    return base + (plus ? 1 : 0);
  endfunction

  // Illegal when the main count is under 3 or the swallow count reaches it.
  function automatic logic bad_cfg(input int n, input int a);
    return (n < 3) || (a >= n);
  endfunction

endpackage

// File: rtl/swallow_prescaler.sv
module swallow_prescaler #(
  parameter int LOW_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic wide,
  input  logic plus,
  output logic tick
);
  localparam int CW = LOW_LOG2 + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  // modulus is read at the end of the period, after the counters settle
  assign last = CW'(swallow_pkg::pre_len(LOW_LOG2, wide, plus) - 1);
  assign tick = !hold && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (hold) cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swallow_counters.sv
module swallow_counters #(
  parameter int N_W = 11,
  parameter int A_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           tick,
  input  logic           cyc_end,
  input  logic [N_W-1:0] n_in,
  input  logic [A_W-1:0] a_in,
  input  logic           wide_in,
  output logic [N_W-1:0] main_rem,
  output logic [A_W-1:0] swal_rem,
  output logic           wide_cur,
  output logic           div_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_rem  <= '0;
      swal_rem  <= '0;
      wide_cur  <= 1'b0;
      div_pulse <= 1'b0;
    end else if (hold || cyc_end) begin
      main_rem  <= n_in;
      swal_rem  <= a_in;
      wide_cur  <= wide_in;
      div_pulse <= !hold;
    end else begin
      div_pulse <= 1'b0;
      if (tick) begin
        main_rem <= main_rem - 1'b1;
        if (swal_rem != '0) swal_rem <= swal_rem - 1'b1;
      end
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int N_W      = 11,
  parameter int A_W      = 7,
  parameter int LOW_LOG2 = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_save,
  input  logic           wide_mod,
  input  logic [N_W-1:0] n_cnt,
  input  logic [A_W-1:0] a_cnt,
  output logic           mod_ctl,
  output logic           pre_out,
  output logic           div_out,
  output logic           cfg_bad
);
  logic           pre_tick;
  logic           cyc_end;
  logic           wide_cur;
  logic [N_W-1:0] main_rem;
  logic [A_W-1:0] swal_rem;

  // events brought out for the checker
  assign mod_ctl = (swal_rem != '0);
  assign cyc_end = pre_tick && (main_rem <= N_W'(1));
  assign pre_out = pre_tick;
  assign cfg_bad = swallow_pkg::bad_cfg(int'(n_cnt), int'(a_cnt));

  swallow_prescaler #(.LOW_LOG2(LOW_LOG2)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (pwr_save),
    .wide  (wide_cur),
    .plus  (mod_ctl),
    .tick  (pre_tick)
  );

  swallow_counters #(.N_W(N_W), .A_W(A_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (pwr_save),
    .tick      (pre_tick),
    .cyc_end   (cyc_end),
    .n_in      (n_cnt),
    .a_in      (a_cnt),
    .wide_in   (wide_mod),
    .main_rem  (main_rem),
    .swal_rem  (swal_rem),
    .wide_cur  (wide_cur),
    .div_pulse (div_out)
  );
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int A_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwr_save,
  input logic [A_W-1:0] a_cnt,
  input logic           mod_ctl,
  input logic           div_out,
  input logic           cyc_end,
  input logic           wide_cur
);
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save |=> !div_out); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out); // R8

  AST_PULSE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !pwr_save) |=> div_out); // R8

  AST_MOD_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_ctl && !cyc_end && !pwr_save) |=> !mod_ctl); // R3

  AST_ZERO_A_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !pwr_save && a_cnt == '0) |=> !mod_ctl); // R4

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_end && !pwr_save) |=> $stable(wide_cur)); // R5
endmodule

bind swallow_divider swallow_divider_chk #(.A_W(A_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_save (pwr_save),
  .a_cnt    (a_cnt),
  .mod_ctl  (mod_ctl),
  .div_out  (div_out),
  .cyc_end  (cyc_end),
  .wide_cur (wide_cur)
);

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
  localparam int CLK_P = 10;
  localparam int WAIT_MAX = 40000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_save = 1'b1;
  logic        wide_mod = 1'b0;
  logic [10:0] n_cnt = 11'd4;
  logic [6:0]  a_cnt = 7'd0;
  logic        mod_ctl, pre_out, div_out, cfg_bad;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  swallow_divider uut (
    .clk(clk), .rst_n(rst_n), .pwr_save(pwr_save), .wide_mod(wide_mod),
    .n_cnt(n_cnt), .a_cnt(a_cnt), .mod_ctl(mod_ctl), .pre_out(pre_out),
    .div_out(div_out), .cfg_bad(cfg_bad)
  );

  task automatic check(input string req, input int got, input int want);
    total++;
    if (got != want) begin
      bad++;
      $display("FAIL %s got=%0d want=%0d", req, got, want);
    end
  endtask

  // expected period: A slow periods of M+1 plus N-A of M
  function automatic int want_period(input int n, input int a, input bit w);
    int m;
    m = w ? 128 : 64;
    return (m + 1) * a + m * (n - a);
  endfunction

  // counts negedges up to and including the next div_out pulse
  task automatic next_pulse(output int cyc, output int hi);
    cyc = 0; hi = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (mod_ctl) hi++;
    end while (!div_out && cyc < WAIT_MAX);
  endtask

  initial begin
    #(CLK_P * 195000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, hi, c2;
    repeat (3) @(negedge clk);
    // reset state
    check("reset div_out", int'(div_out), 0);
    check("reset mod_ctl", int'(mod_ctl), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: held quiet, then exact latency after release
    begin
      int seen = 0;
      n_cnt = 11'd5; a_cnt = 7'd2; wide_mod = 1'b0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (div_out) seen++;
      end
      check("R6 no pulse in power save", seen, 0);
      pwr_save = 1'b0;
      next_pulse(cyc, hi);
      check("R6 first pulse after release", cyc, want_period(5, 2, 0));
    end

    // R1 R2 R3 R4: sweep of small settings on both moduli
    for (int w = 0; w < 2; w++) begin
      for (int n = 3; n <= 6; n++) begin
        for (int a = 0; a < n; a++) begin
          wide_mod = w[0]; n_cnt = 11'(n); a_cnt = 7'(a);
          next_pulse(cyc, hi);
          next_pulse(cyc, hi);
          check($sformatf("R1 R2 period n=%0d a=%0d w=%0d", n, a, w), cyc, want_period(n, a, w[0]));
          if (a == 0) check("R4 mod never high", hi, 0);
          else check($sformatf("R3 mod high cycles n=%0d a=%0d", n, a), hi, a * (w ? 129 : 65));
        end
      end
    end

    // R1 R3: largest swallow count
    wide_mod = 1'b0; n_cnt = 11'd128; a_cnt = 7'd127;
    next_pulse(cyc, hi);
    next_pulse(cyc, hi);
    check("R1 period n=128 a=127", cyc, want_period(128, 127, 0));
    check("R3 mod high n=128 a=127", hi, 127 * 65);

    // R5: mid-period change keeps the current period length
    wide_mod = 1'b0; n_cnt = 11'd4; a_cnt = 7'd1;
    next_pulse(cyc, hi);
    next_pulse(cyc, hi);
    c2 = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      c2++;
    end
    n_cnt = 11'd5; a_cnt = 7'd3; wide_mod = 1'b1;
    next_pulse(cyc, hi);
    check("R5 period with mid change", cyc + c2, want_period(4, 1, 0));
    next_pulse(cyc, hi);
    check("R5 following period", cyc, want_period(5, 3, 1));

    // R8: pulse width is one cycle
    @(negedge clk);
    check("R8 pulse single cycle", int'(div_out), 0);

    // R7: flag sweep
    pwr_save = 1'b1;
    for (int n = 0; n <= 20; n++) begin
      for (int a = 0; a < 32; a++) begin
        n_cnt = 11'(n); a_cnt = 7'(a);
        #1;
        check($sformatf("R7 flag n=%0d a=%0d", n, a), int'(cfg_bad), (n >= 3 && a < n) ? 0 : 1);
      end
    end
    n_cnt = 11'd2047; a_cnt = 7'd127; #1;
    check("R7 flag max legal", int'(cfg_bad), 0);
    n_cnt = 11'd127; a_cnt = 7'd127; #1;
    check("R7 flag a equals n", int'(cfg_bad), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule